// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block gives software control of up to 32 general-purpose pins through a small bank of 32-bit registers. A word-addressed bus carries the register index, a write strobe, write data and combinational read data. Each pin can drive a latched output value or act as an input. Inputs pass through a two-stage synchroniser. The synchronised levels can be read back, and they also feed a per-pin trigger detector.

Three per-pin bit planes set how a pin raises an interrupt: a mode plane that picks edge or level, a sense plane that picks polarity, and a dual plane that makes an edge pin fire on any transition. Detected events are latched in a status register. Software clears them by writing ones to a separate clear register. The latched events, ANDed with an enable mask, form the pending register, and one interrupt line is the OR of all pending bits. A version register reports whether dual-edge triggering is present.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), the direction, mode and sense planes read all ones for implemented pins, the enable, status, dual and output planes read 0, and irq is 0.
- R2: Word 1 is the direction plane (1 = input, 0 = output) and pin_oe is its inverse. Word 0 writes the output latch that drives pin_out.
- R3: A read of word 0 returns the pin_in levels after two clock edges of synchronisation.
- R4: With mode bit 0 (level), sense 1 sets the status bit on every cycle the synchronised pin is high, and sense 0 on every cycle it is low. A clear has no lasting effect while the level stays active.
- R5: With mode bit 1 and dual bit 0, sense 1 latches only rising edges and sense 0 only falling edges. The status bit appears on the third clock edge after the pin changes.
- R6: With mode bit 1 and dual bit 1 (word 9), both rising and falling transitions latch the status bit.
- R7: Writing word 5 clears every status bit (word 3) whose data bit is 1 and leaves the others unchanged. Word 5 reads 0.
- R8: If a new event for a pin and a clear of the same pin land on the same clock edge, the status bit stays set.
- R9: Word 4 (pending) reads status AND enable (word 2), and irq is high exactly when pending is non-zero.
- R10: Word 8 reads the version value, which is 3 by default and never below 3.
- R11: Register bits at or above the pin count read 0, and unmapped words (10 to 15) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_word | input | 4 | Register word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_word |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Output enable, 1 where the pin is an output |
| irq | output | 1 | OR of all pending bits |

## Verification
The bench targets the event/clear collision on a dual-edge pin. A design where the clear wins would lose a transition and read the bit back as 0. It counts the exact edge on which a status bit appears, so a missing or extra synchroniser stage shows up as a bit one cycle early or late. It drives the edge that a single-edge pin must ignore, which catches a swapped sense. It also clears a level source that is still active, and a design that stores level events as one-shot edges would then read 0. Finally, it writes all ones to every plane and reads the upper bits and unmapped words back, which catches unmasked storage beyond the pin count.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int MAX_PINS = 32;

    typedef enum logic [3:0] {
        W_VAL  = 4'd0,
        W_DIR  = 4'd1,
        W_IEN  = 4'd2,
        W_STAT = 4'd3,
        W_PEND = 4'd4,
        W_CLR  = 4'd5,
        W_ESEL = 4'd6,
        W_POL  = 4'd7,
        W_VER  = 4'd8,
        W_BOTH = 4'd9
    } reg_word_e;

    typedef struct packed {
        logic [MAX_PINS-1:0] outv;
        logic [MAX_PINS-1:0] dir;
        logic [MAX_PINS-1:0] ien;
        logic [MAX_PINS-1:0] status;
        logic [MAX_PINS-1:0] esel;
        logic [MAX_PINS-1:0] pol;
        logic [MAX_PINS-1:0] both;
    } gpio_state_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] edge_mode_i,
    input  logic [W-1:0] sense_i,
    input  logic [W-1:0] dual_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;
        always_comb begin
            rise     = lvl_i[i] & ~prev_q[i];
            fall     = ~lvl_i[i] & prev_q[i];
            lvl_hit  = sense_i[i] ? lvl_i[i] : ~lvl_i[i];
            edge_hit = dual_i[i] ? (rise | fall) : (sense_i[i] ? rise : fall);
            evt_o[i] = edge_mode_i[i] ? edge_hit : lvl_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int          NPINS   = 16,
    parameter logic [31:0] VERSION = 32'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       bus_word,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    localparam logic [MAX_PINS-1:0] PIN_MASK =
        (NPINS >= MAX_PINS) ? {MAX_PINS{1'b1}} : ((32'd1 << NPINS) - 32'd1);

    gpio_state_t r_d, r_q;

    logic [NPINS-1:0]    sync_lvl, evt;
    logic [MAX_PINS-1:0] sync_x, evt_x, clr_mask, wmask;
    logic [NPINS-1:0]    stat_w, ien_w;

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_lvl)
    );

    gpio_trig_detect #(.W(NPINS)) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_i       (sync_lvl),
        .edge_mode_i (r_q.esel[NPINS-1:0]),
        .sense_i     (r_q.pol[NPINS-1:0]),
        .dual_i      (r_q.both[NPINS-1:0]),
        .evt_o       (evt)
    );

    always_comb begin
        sync_x = '0;
        sync_x[NPINS-1:0] = sync_lvl;
        evt_x = '0;
        evt_x[NPINS-1:0] = evt;
    end

    // next-state process
    always_comb begin
        r_d      = r_q;
        wmask    = bus_wdata & PIN_MASK;
        clr_mask = '0;
        if (bus_we) begin
            case (reg_word_e'(bus_word))
                W_VAL:   r_d.outv = wmask;
                W_DIR:   r_d.dir  = wmask;
                W_IEN:   r_d.ien  = wmask;
                W_CLR:   clr_mask = wmask;
                W_ESEL:  r_d.esel = wmask;
                W_POL:   r_d.pol  = wmask;
                W_BOTH:  r_d.both = wmask;
                default: ;
            endcase
        end
        // a fresh event outranks a clear on the same edge
        r_d.status = (r_q.status & ~clr_mask) | evt_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.outv   <= '0;
            r_q.dir    <= PIN_MASK;
            r_q.ien    <= '0;
            r_q.status <= '0;
            r_q.esel   <= PIN_MASK;
            r_q.pol    <= PIN_MASK;
            r_q.both   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_word_e'(bus_word))
            W_VAL:   bus_rdata = sync_x;
            W_DIR:   bus_rdata = r_q.dir;
            W_IEN:   bus_rdata = r_q.ien;
            W_STAT:  bus_rdata = r_q.status;
            W_PEND:  bus_rdata = r_q.status & r_q.ien;
            W_ESEL:  bus_rdata = r_q.esel;
            W_POL:   bus_rdata = r_q.pol;
            W_VER:   bus_rdata = VERSION;
            W_BOTH:  bus_rdata = r_q.both;
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = r_q.outv[NPINS-1:0];
    assign pin_oe  = ~r_q.dir[NPINS-1:0];
    assign irq     = |(r_q.status & r_q.ien);
    assign stat_w  = r_q.status[NPINS-1:0];
    assign ien_w   = r_q.ien[NPINS-1:0];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       bus_word,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] stat,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] evt
);
    logic [NPINS-1:0] clr_m;
    assign clr_m = (bus_we && bus_word == W_CLR) ? bus_wdata[NPINS-1:0] : '0;

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word == W_DIR) |=> (pin_oe == ~$past(bus_wdata[NPINS-1:0]))); // R2

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat) & ~$past(clr_m)) & ~stat) == '0)); // R7

    AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat & ~$past(stat)) & ~$past(evt)) == '0)); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt) & ~stat) == '0)); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat & ien) != '0)); // R9

    AST_VERSION_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word == W_VER) |-> (bus_rdata >= 32'd3)); // R10

    if (NPINS < 32) begin : g_upper
        AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_word != W_VER) |-> (bus_rdata[31:NPINS] == '0)); // R11
    end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_word  (bus_word),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat      (stat_w),
    .ien       (ien_w),
    .evt       (evt)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int NP = 16;
    localparam logic [3:0] A_VAL = 0, A_DIR = 1, A_IEN = 2, A_STAT = 3, A_PEND = 4,
                           A_CLR = 5, A_ESEL = 6, A_POL = 7, A_VER = 8, A_BOTH = 9;

    logic          clk = 0, rst_n = 0, bus_we = 0, irq;
    logic [3:0]    bus_word = 0;
    logic [31:0]   bus_wdata = 0, bus_rdata;
    logic [NP-1:0] pin_in = 0, pin_out, pin_oe;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [3:0] w, input logic [31:0] d);
        bus_word = w; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] w, output logic [31:0] d);
        bus_word = w; #1; d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] w, input logic [31:0] exp);
        logic [31:0] v;
        rd(w, v);
        chk(tag, v, exp);
    endtask

    task automatic settle_clear();
        cyc(4);
        wr(A_CLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        rd_chk("R1 dir", A_DIR, 32'h0000_FFFF);
        chk("R1 oe", pin_oe, 0);
        rd_chk("R1 ien", A_IEN, 0);
        rd_chk("R1 stat", A_STAT, 0);
        rd_chk("R1 esel", A_ESEL, 32'h0000_FFFF);
        rd_chk("R1 pol", A_POL, 32'h0000_FFFF);
        rd_chk("R1 both", A_BOTH, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_dir_out();
        wr(A_DIR, 32'h0000_FF00);
        wr(A_VAL, 32'h0000_00A5);
        chk("R2 oe", pin_oe, 16'h00FF);
        chk("R2 out", pin_out, 16'h00A5);
        rd_chk("R2 dir readback", A_DIR, 32'h0000_FF00);
    endtask

    task automatic t_value_sync();
        pin_in = 16'h1234;
        cyc(1);
        rd_chk("R3 one edge", A_VAL, 0);
        cyc(1);
        rd_chk("R3 two edges", A_VAL, 32'h0000_1234);
        pin_in = 0;
        settle_clear();
        rd_chk("R3 cleanup", A_STAT, 0);
    endtask

    task automatic t_single_edge();
        pin_in[3] = 1;
        cyc(2);
        rd_chk("R5 before third edge", A_STAT, 0);
        cyc(1);
        rd_chk("R5 rising latched", A_STAT, 32'h8);
        wr(A_CLR, 32'h8);
        pin_in[3] = 0;
        cyc(4);
        rd_chk("R5 falling ignored", A_STAT, 0);
        wr(A_POL, 32'hFFF7);
        pin_in[3] = 1;
        cyc(4);
        rd_chk("R5 rising ignored", A_STAT, 0);
        pin_in[3] = 0;
        cyc(4);
        rd_chk("R5 falling latched", A_STAT, 32'h8);
        wr(A_POL, 32'hFFFF);
        wr(A_CLR, 32'hFFFF);
    endtask

    task automatic t_both();
        wr(A_BOTH, 32'h20);
        pin_in[5] = 1;
        cyc(4);
        rd_chk("R6 rise", A_STAT, 32'h20);
        wr(A_CLR, 32'h20);
        rd_chk("R6 cleared", A_STAT, 0);
        pin_in[5] = 0;
        cyc(4);
        rd_chk("R6 fall", A_STAT, 32'h20);
        wr(A_CLR, 32'h20);
        wr(A_BOTH, 0);
    endtask

    task automatic t_level();
        wr(A_ESEL, 32'hFFFB);
        cyc(4);
        rd_chk("R4 inactive low", A_STAT, 0);
        pin_in[2] = 1;
        cyc(4);
        rd_chk("R4 high latched", A_STAT, 32'h4);
        wr(A_CLR, 32'h4);
        rd_chk("R4 clear while active", A_STAT, 32'h4);
        pin_in[2] = 0;
        settle_clear();
        rd_chk("R4 cleared after release", A_STAT, 0);
        wr(A_POL, 32'hFFFB);
        cyc(4);
        rd_chk("R4 active low latched", A_STAT, 32'h4);
        pin_in[2] = 1;
        settle_clear();
        rd_chk("R4 active low released", A_STAT, 0);
        wr(A_ESEL, 32'hFFFF);
        wr(A_POL, 32'hFFFF);
        pin_in[2] = 0;
        settle_clear();
    endtask

    task automatic t_clear();
        pin_in[10:8] = 3'b111;
        cyc(4);
        rd_chk("R7 three set", A_STAT, 32'h700);
        wr(A_CLR, 32'h200);
        rd_chk("R7 one cleared", A_STAT, 32'h500);
        wr(A_CLR, 0);
        rd_chk("R7 zero write no effect", A_STAT, 32'h500);
        rd_chk("R7 clear reads zero", A_CLR, 0);
        pin_in[10:8] = 0;
        settle_clear();
    endtask

    task automatic t_collide();
        wr(A_BOTH, 32'h800);
        pin_in[11] = 1;
        cyc(4);
        rd_chk("R8 preset", A_STAT, 32'h800);
        pin_in[11] = 0;       // falling event reaches status on 3rd edge
        cyc(2);
        wr(A_CLR, 32'h800);   // clear captured on that same edge
        rd_chk("R8 event wins", A_STAT, 32'h800);
        wr(A_CLR, 32'h800);
        rd_chk("R8 later clear works", A_STAT, 0);
        wr(A_BOTH, 0);
    endtask

    task automatic t_irq();
        pin_in[12] = 1;
        cyc(4);
        rd_chk("R9 pend masked", A_PEND, 0);
        chk("R9 irq masked", irq, 0);
        wr(A_IEN, 32'h1000);
        rd_chk("R9 pend enabled", A_PEND, 32'h1000);
        chk("R9 irq high", irq, 1);
        wr(A_IEN, 32'h0800);
        chk("R9 irq other enable", irq, 0);
        wr(A_IEN, 0);
        pin_in[12] = 0;
        settle_clear();
    endtask

    task automatic t_version();
        rd_chk("R10 version", A_VER, 32'd3);
    endtask

    task automatic t_upper();
        wr(A_IEN, 32'hFFFF_FFFF);
        wr(A_ESEL, 32'hFFFF_FFFF);
        wr(A_BOTH, 32'hFFFF_FFFF);
        wr(A_DIR, 32'hFFFF_FFFF);
        rd_chk("R11 ien", A_IEN, 32'h0000_FFFF);
        rd_chk("R11 esel", A_ESEL, 32'h0000_FFFF);
        rd_chk("R11 both", A_BOTH, 32'h0000_FFFF);
        rd_chk("R11 dir", A_DIR, 32'h0000_FFFF);
        rd_chk("R11 unmapped", 4'd12, 0);
        rd_chk("R11 unmapped top", 4'd15, 0);
        wr(A_IEN, 0);
        wr(A_BOTH, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        t_reset();
        t_dir_out();
        t_value_sync();
        t_single_edge();
        t_both();
        t_level();
        t_clear();
        t_collide();
        t_irq();
        t_version();
        t_upper();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule